// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the address for each beat of a four-beat burst to a synchronous pipelined memory. A begin-burst strobe captures an external starting address. While the active-low advance input is held low, the block steps to the next beat on each rising clock edge. All address bits above the lowest two keep their captured value for the whole burst. The lowest two bits follow one of two orderings. Which ordering is used depends on a mode input that is normally held static.

In linear mode the lowest two bits count upward from the start value and wrap modulo four. In interleaved mode they are the start value XOR the beat index. A last-beat flag marks the fourth beat of the burst. One more advance after that wraps the burst back to its starting address. Read bursts and write bursts use the sequencer in exactly the same way, because it has no notion of transfer direction.

Top module: `burst_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets accessAddr to all zeros and lastBeat low.
- R2: When burstStart is high at a rising edge, extAddr is captured, and after that edge accessAddr equals extAddr (beat 1).
- R3: burstStart takes priority over advanceN. A start and an advance in the same cycle give beat 1 of the new burst.
- R4: When advanceN is low and burstStart is low at a rising edge, the beat index (0..3) increments by one.
- R5: When advanceN is high and burstStart is low, accessAddr and lastBeat keep their values.
- R6: With modeInterleave = 0, accessAddr[1:0] on beat index n equals (start[1:0] + n) mod 4.
- R7: With modeInterleave = 1, accessAddr[1:0] on beat index n equals start[1:0] XOR n.
- R8: accessAddr bits above bit 1 always equal the captured start address.
- R9: lastBeat is high exactly when the beat index is 3, which is the fourth beat.
- R10: An advance from the fourth beat returns to beat index 0, which is the starting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| burstStart | input | 1 | Begin-burst strobe, captures extAddr |
| advanceN | input | 1 | Active-low advance to the next beat |
| modeInterleave | input | 1 | 0 = linear ordering, 1 = interleaved ordering |
| extAddr | input | ADDR_W | External starting address |
| accessAddr | output | ADDR_W | Address of the current beat |
| lastBeat | output | 1 | High on the fourth beat |

## Verification
Two situations are hard to reach from the ports. The first is a wrap back to the start after the fourth beat when the start value is not 00, in both orderings. The second is a new start that arrives in the same cycle as an advance in the middle of a burst. The stimulus runs full bursts from every one of the four low-bit start values in each mode, with extra advances past the last beat. It inserts hold cycles between advances. It also raises a start together with an advance partway through a burst, using different upper address bits, so that both the priority rule and the recapture of the upper bits are exercised.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic loadStart;
    logic stepBeat;
  } seqCtrl_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burstStart,
  input  logic              advanceN,
  output seqCtrl_t          ctrl,
  output logic [BEAT_W-1:0] beatIdx,
  output logic              lastBeat
);
  logic [BEAT_W-1:0] beatReg;

  // a start outranks an advance
  always_comb begin
    ctrl.loadStart = burstStart;
    ctrl.stepBeat  = !burstStart && !advanceN;
  end

  always_ff @(posedge clk) begin
    if (rst)                 beatReg <= '0;
    else if (ctrl.loadStart) beatReg <= '0;
    else if (ctrl.stepBeat)  beatReg <= beatReg + 1'b1;
  end

  assign beatIdx  = beatReg;
  assign lastBeat = (beatReg == BEAT_W'(BURST_LEN - 1));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtrl_t          ctrl,
  input  logic [BEAT_W-1:0] beatIdx,
  input  logic              modeInterleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] accessAddr
);
  logic [ADDR_W-1:0] startReg;
  logic [BEAT_W-1:0] linBits, xorBits;

  always_ff @(posedge clk) begin
    if (rst)                 startReg <= '0;
    else if (ctrl.loadStart) startReg <= extAddr;
  end

  assign linBits = startReg[BEAT_W-1:0] + beatIdx;

  for (genvar b = 0; b < BEAT_W; b++) begin : gXor
    assign xorBits[b] = startReg[b] ^ beatIdx[b];
  end

  assign accessAddr = {startReg[ADDR_W-1:BEAT_W], modeInterleave ? xorBits : linBits};
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burstStart,
  input  logic              advanceN,
  input  logic              modeInterleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] accessAddr,
  output logic              lastBeat
);
  localparam int BEAT_W = $clog2(BURST_LEN);
  seqCtrl_t ctrl;
  logic [BEAT_W-1:0] beatIdx;

  burst_seq_ctrl #(.BURST_LEN(BURST_LEN)) uCtrl (
    .clk(clk), .rst(rst), .burstStart(burstStart), .advanceN(advanceN),
    .ctrl(ctrl), .beatIdx(beatIdx), .lastBeat(lastBeat)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) uDp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .beatIdx(beatIdx),
    .modeInterleave(modeInterleave), .extAddr(extAddr), .accessAddr(accessAddr)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int BURST_LEN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              burstStart,
  input logic              advanceN,
  input logic              modeInterleave,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] accessAddr,
  input logic              lastBeat
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (accessAddr == '0 && !lastBeat));

  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    burstStart |=> (accessAddr == $past(extAddr) && !lastBeat));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!burstStart && advanceN) |=>
      (!$stable(modeInterleave) || ($stable(accessAddr) && $stable(lastBeat))));

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!burstStart && !advanceN && !modeInterleave) |=>
      (modeInterleave ||
       accessAddr[BEAT_W-1:0] == BEAT_W'($past(accessAddr[BEAT_W-1:0]) + 1'b1)));

  assert_upper_held_R8: assert property (@(posedge clk) disable iff (rst)
    !burstStart |=> accessAddr[ADDR_W-1:BEAT_W] == $past(accessAddr[ADDR_W-1:BEAT_W]));

  assert_last_leaves_R10: assert property (@(posedge clk) disable iff (rst)
    (lastBeat && !advanceN && !burstStart) |=> !lastBeat);
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) uChk (
  .clk(clk), .rst(rst), .burstStart(burstStart), .advanceN(advanceN),
  .modeInterleave(modeInterleave), .extAddr(extAddr),
  .accessAddr(accessAddr), .lastBeat(lastBeat)
);

// File: tb/sim_burst_seq.sv
module sim_burst_seq;
  localparam int AW = 19;
  logic clk = 0, rst = 1, burstStart = 0, advanceN = 1, modeInterleave = 0;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] accessAddr;
  logic lastBeat;
  int checks = 0, failures = 0;
  logic [AW-1:0] mStart = '0;
  int mBeat = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_seq u0 (.clk(clk), .rst(rst), .burstStart(burstStart), .advanceN(advanceN),
    .modeInterleave(modeInterleave), .extAddr(extAddr),
    .accessAddr(accessAddr), .lastBeat(lastBeat));

  function automatic logic [AW-1:0] expAddr();
    logic [1:0] lo;
    lo = modeInterleave ? (mStart[1:0] ^ 2'(mBeat)) : 2'(int'(mStart[1:0]) + mBeat);
    return {mStart[AW-1:2], lo};
  endfunction

  // one clock: drive, take edge, update model, compare
  task automatic cyc(input logic st, input logic advN, input logic [AW-1:0] a, input string req);
    burstStart = st; advanceN = advN; extAddr = a;
    @(posedge clk); #1;
    if (rst) begin mStart = '0; mBeat = 0; end
    else if (st) begin mStart = a; mBeat = 0; end
    else if (!advN) mBeat = (mBeat + 1) % 4;
    checks++;
    if (accessAddr !== expAddr()) begin
      failures++;
      $display("FAIL %s accessAddr actual=%h expected=%h", req, accessAddr, expAddr());
    end
    checks++;
    if (lastBeat !== (mBeat == 3)) begin
      failures++;
      $display("FAIL R9 (%s) lastBeat actual=%b expected=%b", req, lastBeat, mBeat == 3);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(0, 1, '0, "R1");
    cyc(0, 1, '0, "R1");
    @(negedge clk); rst = 0;
    for (int m = 0; m < 2; m++) begin
      modeInterleave = m[0];
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {17'h0ABCD ^ 17'(s * 4099 + m * 77), 2'(s)};
        cyc(1, 1, a, "R2");
        for (int k = 0; k < 5; k++) begin
          cyc(0, 0, '1, m ? "R7 R4 R10" : "R6 R4 R10");
          if (k == 1) cyc(0, 1, '1, "R5 R8");
        end
        cyc(0, 1, '0, "R5");
      end
      // start colliding with an advance mid-burst
      cyc(1, 1, 19'h12345, "R2");
      cyc(0, 0, '0, "R4");
      cyc(1, 0, 19'h6ABC2, "R3");
      cyc(0, 0, '0, "R3 R8");
      cyc(0, 0, '0, "R9");
      cyc(0, 0, '0, "R9");
      cyc(0, 0, '0, "R10");
    end
    rst = 1;
    cyc(0, 0, '0, "R1");
    rst = 0;
    cyc(0, 1, '0, "R1 R5");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule